// File: doc/BRIEF.md
# Phantom Serial Unlock and Access Sequencer

This block sits on an asynchronous memory bus between the host and a memory device that shares the host's chip-enable. Every strobed bus cycle is one of two kinds. A read is chip-enable together with output-enable. A write is chip-enable together with write-enable. The block watches these cycles for a hidden 64-bit key, sent one bit per write on the single data-in line. While it waits for the key, the memory sees every access unchanged through a forwarded chip-enable.

Once the whole key has been matched in order, the block claims the next 64 strobed cycles for itself and holds the memory disabled. In each of those cycles it moves one bit of an internal 64-bit data register. A write shifts the data-in bit in. A read presents the register's low bit on data-out and rotates the register. The register is also visible as a parallel output, and the timekeeping logic beside it can load it in parallel. Bus pins are synchronised to the system clock, and each cycle is counted once, when its strobe ends.

Top module: `phantom_unlock_seq`

## Requirements
- R1: After reset the key pointer is at the first key bit and no mismatch is recorded. No transfer is active. `data_q` is zero, `mem_ce_n` equals `bus_ce_n`, and `dout_oe` is 0.
- R2: A bus cycle counts once, at the rising edge of `bus_ce_n`, if `bus_we_n` or `bus_oe_n` was low while `bus_ce_n` was low. It is a write if `bus_we_n` was low and a read otherwise. Toggling `bus_oe_n` or `bus_we_n` while `bus_ce_n` stays high has no effect on recognition, transfer or `data_q`.
- R3: A read while the block is not transferring returns the key pointer to the first key bit and clears any recorded mismatch, so that a partly sent key is abandoned.
- R4: During recognition, a write whose `din` differs from the key bit at the pointer records a mismatch. After that, every write is ignored until a read, so the block stays locked even if the rest of the key is sent correctly.
- R5: The key is the parameter `KEY`, compared LSB first: the first write after a reset or a read is compared with `KEY[0]`. 64 consecutive matching writes unlock the block, and the following 64 counted cycles are transfer cycles.
- R6: When no transfer is active, `mem_ce_n` follows `bus_ce_n` combinationally.
- R7: While a transfer is active, `mem_ce_n` is held at 1.
- R8: A transfer write shifts `data_q` right by one and puts `din` into bit 63. After 64 transfer writes, bit i of `data_q` holds the i-th written bit, counting from 0.
- R9: During a transfer read, `dout` equals `data_q[0]` and `dout_oe` is 1 while both `bus_ce_n` and `bus_oe_n` are low. When the cycle ends, `data_q` rotates right by one, with bit 0 moving to bit 63. Outside a transfer read, `dout_oe` is 0.
- R10: After the 64th transfer cycle the block returns to idle with the pointer at the first key bit. Pass-through is restored, and a fresh key is needed for another transfer.
- R11: When `pload` is high in a clock where no transfer is active, `data_q` takes `pdata` at that edge. While a transfer is active, `pload` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Host chip-enable, active low, asynchronous |
| bus_oe_n | input | 1 | Host output-enable, active low, asynchronous |
| bus_we_n | input | 1 | Host write-enable, active low, asynchronous |
| din | input | 1 | Serial data-in line |
| mem_ce_n | output | 1 | Chip-enable forwarded to the memory |
| dout | output | 1 | Serial data-out value |
| dout_oe | output | 1 | Pad drive enable for dout; the pad is tri-state when 0 |
| pload | input | 1 | Parallel load strobe from the timekeeping side |
| pdata | input | 64 | Parallel load value |
| data_q | output | 64 | Data register contents |

## Verification
The bench sends a key with one wrong bit in the middle and then the rest correct. A design that forgot the mismatch would unlock, and the bench would see `mem_ce_n` held high on the next access. The bench also aborts a key halfway with a read and then sends the full key. A design that kept its pointer would stay locked, or would unlock early. It interleaves cycles with chip-enable inactive, both inside the key and inside a transfer. A design that counted them would shift the wrong bits, end the transfer early, or keep the memory disabled. Finally, it checks that 64 transfer reads leave the register unchanged, that the 65th access goes back to the memory, and that a parallel load during a transfer is refused, so that a design with an off-by-one window or an unguarded load would be caught.

// File: rtl/phu_pkg.sv
package phu_pkg;
   typedef enum logic [1:0] {EV_NONE, EV_READ, EV_WRITE} ev_kind_t;

   typedef struct packed {
      ev_kind_t kind;
      logic     bit_v;
   } bus_ev_t;
endpackage

// File: rtl/phu_sync.sv
module phu_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("phu_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phu_cycle_det.sv
module phu_cycle_det
   import phu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    s_ce_n,
   input  logic    s_oe_n,
   input  logic    s_we_n,
   input  logic    s_din,
   output bus_ev_t ev
);
   logic p_ce_n, p_oe_n, p_we_n, p_din;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         p_ce_n <= 1'b1;
         p_oe_n <= 1'b1;
         p_we_n <= 1'b1;
         p_din  <= 1'b0;
      end else begin
         p_ce_n <= s_ce_n;
         p_oe_n <= s_oe_n;
         p_we_n <= s_we_n;
         p_din  <= s_din;
      end

   always_comb begin
      ev.kind  = EV_NONE;
      ev.bit_v = p_din;
      if (!p_ce_n && s_ce_n) begin
         if (!p_we_n)      ev.kind = EV_WRITE;
         else if (!p_oe_n) ev.kind = EV_READ;
      end
   end
endmodule

// File: rtl/phu_matcher.sv
module phu_matcher
   import phu_pkg::*;
#(
   parameter int KEY_BITS = 64,
   parameter logic [KEY_BITS-1:0] KEY = '0,
   localparam int PW = $clog2(KEY_BITS),
   localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_ev_t       ev,
   input  logic          busy,
   output logic          unlock,
   output logic [PW-1:0] ptr,
   output logic          fail
);
   logic hit;

   assign hit    = (ev.bit_v == KEY[ptr]);
   assign unlock = !busy && (ev.kind == EV_WRITE) && !fail && hit && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr  <= '0;
         fail <= 1'b0;
      end else if (!busy) begin
         if (ev.kind == EV_READ) begin
            ptr  <= '0;
            fail <= 1'b0;
         end else if (ev.kind == EV_WRITE && !fail) begin
            if (!hit)              fail <= 1'b1;
            else if (ptr == LAST)  ptr  <= '0;
            else                   ptr  <= ptr + 1'b1;
         end
      end

   // R4: after a mismatch the pointer stays put until a read
   assert_ptr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && ev.kind != EV_READ) |=> ($stable(ptr) && fail));

   // R3: a read outside a transfer rewinds the pointer
   assert_read_rewinds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.kind == EV_READ && !busy) |=> (ptr == '0 && !fail));
endmodule

// File: rtl/phu_xfer_reg.sv
module phu_xfer_reg
   import phu_pkg::*;
#(
   parameter int XFER_BITS = 64,
   localparam int CW = $clog2(XFER_BITS),
   localparam logic [CW-1:0] LAST = CW'(XFER_BITS - 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_ev_t              ev,
   input  logic                 unlock,
   input  logic                 pload,
   input  logic [XFER_BITS-1:0] pdata,
   output logic                 active,
   output logic [XFER_BITS-1:0] data_q
);
   logic [CW-1:0] cnt;
   logic          step;

   assign step = active && (ev.kind != EV_NONE);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (unlock) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (step) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) begin
            active <= 1'b0;
            cnt    <= '0;
         end
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         data_q <= '0;
      else if (step)
         data_q <= {(ev.kind == EV_WRITE) ? ev.bit_v : data_q[0], data_q[XFER_BITS-1:1]};
      else if (!active && pload)
         data_q <= pdata;

   // R11: a load request during a transfer leaves the register alone
   assert_load_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pload && ev.kind == EV_NONE) |=> $stable(data_q));

   // R10: the last counted cycle ends the transfer
   assert_window_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == LAST && !unlock) |=> !active);
endmodule

// File: rtl/phantom_unlock_seq.sv
module phantom_unlock_seq
   import phu_pkg::*;
#(
   parameter int KEY_BITS = 64,
   parameter logic [KEY_BITS-1:0] KEY = 64'h9E37_79B9_7F4A_7C15,
   parameter int XFER_BITS = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_ce_n,
   input  logic                 bus_oe_n,
   input  logic                 bus_we_n,
   input  logic                 din,
   output logic                 mem_ce_n,
   output logic                 dout,
   output logic                 dout_oe,
   input  logic                 pload,
   input  logic [XFER_BITS-1:0] pdata,
   output logic [XFER_BITS-1:0] data_q
);
   localparam int PW = $clog2(KEY_BITS);

   if (KEY_BITS < 2) begin : g_bad_key
      $error("phantom_unlock_seq: KEY_BITS must be at least 2");
   end
   if (XFER_BITS < 2) begin : g_bad_xfer
      $error("phantom_unlock_seq: XFER_BITS must be at least 2");
   end

   logic [3:0] s_bus;
   bus_ev_t    ev;
   logic       unlock, active, fail;
   logic [PW-1:0] ptr;

   phu_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({bus_ce_n, bus_oe_n, bus_we_n, din}),
      .q(s_bus)
   );

   phu_cycle_det u_det (
      .clk(clk), .rst_n(rst_n),
      .s_ce_n(s_bus[3]), .s_oe_n(s_bus[2]), .s_we_n(s_bus[1]), .s_din(s_bus[0]),
      .ev(ev)
   );

   phu_matcher #(.KEY_BITS(KEY_BITS), .KEY(KEY)) u_match (
      .clk(clk), .rst_n(rst_n), .ev(ev), .busy(active),
      .unlock(unlock), .ptr(ptr), .fail(fail)
   );

   phu_xfer_reg #(.XFER_BITS(XFER_BITS)) u_xfer (
      .clk(clk), .rst_n(rst_n), .ev(ev), .unlock(unlock),
      .pload(pload), .pdata(pdata), .active(active), .data_q(data_q)
   );

   assign mem_ce_n = active | bus_ce_n;
   assign dout     = data_q[0];
   assign dout_oe  = active & ~bus_ce_n & ~bus_oe_n;

   // R5: a completed key opens the transfer window on the next clock
   assert_key_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unlock |=> active);

   // R3: while a transfer runs the matcher is idle at the first key bit
   assert_matcher_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ptr == '0 && !fail));
endmodule

// File: tb/tb_phantom_unlock_seq.sv
module tb_phantom_unlock_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] KEY = 64'h9E37_79B9_7F4A_7C15;

   logic clk = 0, rst_n = 0;
   logic bus_ce_n = 1, bus_oe_n = 1, bus_we_n = 1, din = 0;
   logic pload = 0;
   logic [63:0] pdata = '0;
   logic mem_ce_n, dout, dout_oe;
   logic [63:0] data_q;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit settle = 1, done = 0;

   // reference model state
   int m_ptr = 0;
   bit m_fail = 0, m_xfer = 0;
   int m_cnt = 0;
   logic [63:0] m_data = '0;

   phantom_unlock_seq #(.KEY(KEY)) dut (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
      .bus_we_n(bus_we_n), .din(din), .mem_ce_n(mem_ce_n), .dout(dout),
      .dout_oe(dout_oe), .pload(pload), .pdata(pdata), .data_q(data_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(mem_ce_n == (m_xfer ? 1'b1 : bus_ce_n), m_xfer ? "R7 mem_ce_n" : "R6 mem_ce_n",
               64'(mem_ce_n), 64'(m_xfer ? 1'b1 : bus_ce_n));
         check(dout_oe == (m_xfer && !bus_ce_n && !bus_oe_n), "R9 dout_oe",
               64'(dout_oe), 64'(m_xfer && !bus_ce_n && !bus_oe_n));
         if (dout_oe) check(dout == m_data[0], "R9 dout", 64'(dout), 64'(m_data[0]));
         if (!settle) check(data_q == m_data, "R8 data_q", data_q, m_data);
      end
   end

   task automatic model_ev(input bit is_wr, input bit b);
      if (m_xfer) begin
         m_data = {is_wr ? b : m_data[0], m_data[63:1]};
         m_cnt++;
         if (m_cnt == 64) begin m_xfer = 0; m_cnt = 0; end
      end else if (!is_wr) begin
         m_ptr = 0; m_fail = 0;
      end else if (!m_fail) begin
         if (b == KEY[m_ptr]) begin
            m_ptr++;
            if (m_ptr == 64) begin m_ptr = 0; m_xfer = 1; m_cnt = 0; end
         end else m_fail = 1;
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_cyc(input bit is_wr, input bit b);
      tick(1);
      if (is_wr) bus_we_n = 0; else bus_oe_n = 0;
      din = b;
      tick(3);
      bus_ce_n = 0;
      tick(4);
      bus_ce_n = 1; settle = 1;
      tick(2);
      bus_we_n = 1; bus_oe_n = 1;
      tick(5);
      model_ev(is_wr, b);
      settle = 0;
   endtask

   task automatic foreign(input bit is_wr);
      tick(1);
      if (is_wr) bus_we_n = 0; else bus_oe_n = 0;
      din = 1;
      tick(6);
      bus_we_n = 1; bus_oe_n = 1;
      tick(2);
   endtask

   task automatic send_key(input int interleave_at);
      bus_cyc(0, 0);
      for (int i = 0; i < 64; i++) begin
         if (i == interleave_at) begin foreign(1); foreign(0); end
         bus_cyc(1, KEY[i]);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick(2);
      settle = 0;
      // R1: reset state
      check(data_q == 64'h0, "R1 data_q", data_q, 64'h0);
      check(mem_ce_n == bus_ce_n, "R1 mem_ce_n", 64'(mem_ce_n), 64'(bus_ce_n));
      check(dout_oe == 1'b0, "R1 dout_oe", 64'(dout_oe), 64'h0);

      // R5 R8: unlock with LSB-first key, then 64 transfer writes
      send_key(-1);
      check(m_xfer == 1, "R5 model unlocked", 64'(m_xfer), 64'h1);
      for (int i = 0; i < 64; i++) bus_cyc(1, (i % 3) == 0);
      begin
         logic [63:0] e = '0;
         for (int i = 0; i < 64; i++) e[i] = (i % 3) == 0;
         check(data_q == e, "R8 written pattern", data_q, e);
      end
      // R10: next access goes to memory, is not a transfer
      bus_cyc(1, 1);
      check(data_q == m_data, "R10 after window", data_q, m_data);

      // R9: 64 reads return the pattern and leave the register unchanged
      send_key(-1);
      for (int i = 0; i < 64; i++) bus_cyc(0, 0);
      check(data_q == m_data, "R9 rotate restores", data_q, m_data);

      // R4: one wrong bit then the correct remainder stays locked
      bus_cyc(0, 0);
      for (int i = 0; i < 64; i++) bus_cyc(1, (i == 10) ? ~KEY[i] : KEY[i]);
      check(m_xfer == 0, "R4 model locked", 64'(m_xfer), 64'h0);
      bus_cyc(1, 0);
      check(data_q == m_data, "R4 write ignored", data_q, m_data);

      // R3: abort halfway with a read, then full key unlocks
      for (int i = 0; i < 30; i++) bus_cyc(1, KEY[i]);
      send_key(-1);
      check(m_xfer == 1, "R3 unlocked after abort", 64'(m_xfer), 64'h1);

      // R2: chip-enable-inactive cycles inside the transfer are ignored
      for (int i = 0; i < 64; i++) begin
         if (i == 20) begin foreign(1); foreign(0); end
         bus_cyc(1, (i % 5) == 1);
      end
      check(m_xfer == 0, "R2 window closed", 64'(m_xfer), 64'h0);
      check(data_q == m_data, "R2 transfer data", data_q, m_data);

      // R2: interleaved inside the key
      send_key(33);
      check(m_xfer == 1, "R2 key with interleave", 64'(m_xfer), 64'h1);

      // R11: load refused during transfer
      tick(1); pload = 1; pdata = 64'hDEAD_BEEF_0123_4567; settle = 1;
      tick(1); pload = 0;
      tick(2); settle = 0;
      check(data_q == m_data, "R11 load refused", data_q, m_data);
      for (int i = 0; i < 64; i++) bus_cyc(0, 0);

      // R11: load accepted when idle
      tick(1); pload = 1; pdata = 64'hA5A5_0F0F_3C3C_9999; settle = 1;
      tick(1); pload = 0; m_data = 64'hA5A5_0F0F_3C3C_9999;
      tick(2); settle = 0;
      check(data_q == 64'hA5A5_0F0F_3C3C_9999, "R11 load idle", data_q, 64'hA5A5_0F0F_3C3C_9999);

      tick(4);
      done = 1;
      finish_run();
   end
endmodule